// File: doc/BRIEF.md
# SPI Serial EEPROM Command Slave

This block is the command front end of a byte-addressed serial EEPROM. It acts as an SPI mode-0 slave. A bus master selects it by pulling `cs_ni` low, then sends an opcode byte. Address and data bytes follow as the opcode requires. All traffic is most significant bit first. The block serves reads and writes from a small internal byte array, and it keeps a status byte that holds a write-enable latch, a busy flag, a write-protect enable and two general block bits.

All SPI pins are synchronised into the system clock domain and edge-detected there. For this reason the system clock must run several times faster than the serial clock. A completed array write or status write starts a self-timed internal cycle of `WR_CYCLES` system clocks. During that cycle only status reads are served.

The `hold_ni` pin freezes a transfer in mid-flight without losing its position. An unknown opcode silences the device until the next frame. The `wp_ni` pin guards status writes, but only when the protect-enable bit is set.

Top module: `spi_eeprom_slave`

## Requirements
- R1: While `cs_ni` is high, SCK and MOSI activity has no effect on internal state, and `miso_oe_o` stays 0.
- R2: Mode 0 timing applies. MOSI is sampled on the SCK rising edge, and `miso_o` changes only after an SCK falling edge. Both directions are MSB first.
- R3: The first byte of a frame is the opcode. The opcode values are:
  - 0x06 sets the write-enable latch.
  - 0x04 clears the write-enable latch.
  - 0x05 streams the status byte.
  - 0x01 writes the status byte.
  - 0x03 reads the array.
  - 0x02 writes the array.
- R4: Any other opcode locks the frame. No further bits are taken in, and `miso_oe_o` stays 0 until the next falling edge of `cs_ni`.
- R5: A read takes a 16-bit address, high byte first, and uses only the low `MEM_AW` bits. Each further byte returns the next location, wrapping over the whole array.
- R6: A write is accepted only when the write-enable latch is 1. Consecutive data bytes advance the address only within the `2**PAGE_AW`-byte page, wrapping to the page start.
- R7: The status byte is laid out as {protect-enable[7], 0[6:4], block bits[3:2], write-enable latch[1], busy[0]}. A status write loads bits 7, 3 and 2.
- R8: An accepted write starts the internal cycle when `cs_ni` rises. Busy reads 1 for `WR_CYCLES` clocks, and the write-enable latch clears when the cycle ends.
- R9: While busy, every opcode except 0x05 is ignored without lockout.
- R10: A change of `hold_ni` takes effect only while SCK is low. While hold is active, SCK edges are ignored and `miso_oe_o` is 0. Releasing hold resumes the transfer where it stopped.
- R11: With protect-enable set and `wp_ni` low, a status write is refused, and the write-enable latch stays set. With protect-enable clear, `wp_ni` has no effect.
- R12: If `wp_ni` falls before `cs_ni` rises on a status write while protect-enable is set, the write is dropped. Once the internal cycle has started, `wp_ni` has no effect on it.
- R13: After reset, the status byte reads 0x00 and `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Transfer pause, active low |
| wp_ni | input | 1 | Status write protect, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the `miso_o` tri-state driver |

## Verification
The hardest situation to reach is a status write that was legal when its data byte arrived but becomes illegal before the frame closes. The bench sets protect-enable first and leaves the write-enable latch set. It then sends a full status-write frame, drops `wp_ni` while select is still low, and raises select afterwards. Reading the status back must show the old byte with the latch still set.

A second frame drops `wp_ni` only after select has risen, to show that a write cycle already under way still completes. Hold is exercised in the middle of the address byte, with SCK toggling garbage during the pause, so that any leaked edge would corrupt the address and show up as wrong read data.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADH, ST_ADL, ST_RD, ST_WR, ST_WSR, ST_RSR, ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic sel_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o,
  output logic wp_low_o,
  output logic hold_o
);
  localparam int unsigned NPIN = 5;
  // pin order {cs_n, sck, mosi, hold_n, wp_n}
  localparam logic [NPIN-1:0] IDLE_VAL = 5'b10011;

  logic [NPIN-1:0] raw, pin_s;
  assign raw = {cs_ni, sck_i, mosi_i, hold_ni, wp_ni};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {SYNC_STAGES{IDLE_VAL[g]}};
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign pin_s[g] = sh_q[SYNC_STAGES-1];
  end

  logic cs_n_s, sck_s, hold_n_s;
  assign cs_n_s   = pin_s[4];
  assign sck_s    = pin_s[3];
  assign mosi_o   = pin_s[2];
  assign hold_n_s = pin_s[1];
  assign wp_low_o = ~pin_s[0];

  logic sck_d, cs_d, hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      if (cs_n_s)      hold_q <= 1'b0;
      else if (!sck_s) hold_q <= ~hold_n_s;  // hold only moves while sck low
    end
  end

  assign sel_o         = ~cs_n_s;
  assign hold_o        = hold_q;
  assign frame_start_o = cs_d & ~cs_n_s;
  assign frame_end_o   = ~cs_d & cs_n_s;
  assign rise_o        = sck_s & ~sck_d & ~cs_n_s & ~hold_q;
  assign fall_o        = ~sck_s & sck_d & ~cs_n_s & ~hold_q;
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == CW'(CYCLES - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(CYCLES)));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int unsigned MEM_AW      = 6,
  parameter int unsigned PAGE_AW     = 3,
  parameter int unsigned WR_CYCLES   = 500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic miso_o,
  output logic miso_oe_o
);
  logic sel, frame_start, frame_end, rise, fall, mosi_s, wp_low, hold;
  logic busy, tmr_done, tmr_start;

  spi_ee_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i, .hold_ni, .wp_ni,
    .sel_o(sel), .frame_start_o(frame_start), .frame_end_o(frame_end),
    .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s), .wp_low_o(wp_low),
    .hold_o(hold)
  );

  spi_ee_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(tmr_start), .busy_o(busy), .done_o(tmr_done)
  );

  ee_state_e   st_q;
  logic [2:0]  bit_q;
  logic [6:0]  sr_q;
  logic [7:0]  tx_q;
  logic [15:0] addr_q;
  logic        lock_q, out_q, load_q, rd_q;
  logic        pend_sr_q, pend_wr_q;
  logic        wel_q, wpen_q, wpen_new_q;
  logic [1:0]  bp_q, bp_new_q;
  logic        miso_q, oe_q;

  logic [7:0] byte_in, status, mem_rdata;
  logic       byte_done, mem_we, wp_block, sr_go;

  assign byte_in   = {sr_q, mosi_s};
  assign byte_done = rise && !lock_q && (bit_q == 3'd7);
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, busy};
  assign mem_we    = byte_done && (st_q == ST_WR);
  assign wp_block  = wpen_q & wp_low;
  assign sr_go     = pend_sr_q & ~wp_block;
  assign tmr_start = frame_end & (sr_go | pend_wr_q);

  spi_ee_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(addr_q[MEM_AW-1:0]), .wdata_i(byte_in),
    .raddr_i(addr_q[MEM_AW-1:0]), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OPC;
      bit_q      <= '0;
      sr_q       <= '0;
      tx_q       <= '0;
      addr_q     <= '0;
      lock_q     <= 1'b0;
      out_q      <= 1'b0;
      load_q     <= 1'b0;
      rd_q       <= 1'b0;
      pend_sr_q  <= 1'b0;
      pend_wr_q  <= 1'b0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      wpen_new_q <= 1'b0;
      bp_q       <= '0;
      bp_new_q   <= '0;
      miso_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      if (frame_start) begin
        st_q      <= ST_OPC;
        bit_q     <= '0;
        lock_q    <= 1'b0;
        out_q     <= 1'b0;
        load_q    <= 1'b0;
        pend_sr_q <= 1'b0;
        pend_wr_q <= 1'b0;
      end else if (rise && !lock_q) begin
        sr_q  <= byte_in[6:0];
        bit_q <= bit_q + 1'b1;
        if (bit_q == 3'd7) begin
          case (st_q)
            ST_OPC: begin
              if (busy && byte_in != OP_RDSR) st_q <= ST_SKIP;
              else begin
                case (byte_in)
                  OP_WREN:  begin wel_q <= 1'b1; st_q <= ST_SKIP; end
                  OP_WRDI:  begin wel_q <= 1'b0; st_q <= ST_SKIP; end
                  OP_RDSR:  begin st_q <= ST_RSR; out_q <= 1'b1; load_q <= 1'b1; end
                  OP_WRSR:  st_q <= wel_q ? ST_WSR : ST_SKIP;
                  OP_READ:  begin rd_q <= 1'b1; st_q <= ST_ADH; end
                  OP_WRITE: begin rd_q <= 1'b0; st_q <= wel_q ? ST_ADH : ST_SKIP; end
                  default:  lock_q <= 1'b1;
                endcase
              end
            end
            ST_ADH: begin
              addr_q[15:8] <= byte_in;
              st_q         <= ST_ADL;
            end
            ST_ADL: begin
              addr_q[7:0] <= byte_in;
              if (rd_q) begin
                st_q   <= ST_RD;
                out_q  <= 1'b1;
                load_q <= 1'b1;
              end else begin
                st_q <= ST_WR;
              end
            end
            ST_RD: begin
              addr_q <= addr_q + 1'b1;
              load_q <= 1'b1;
            end
            ST_WR: begin
              addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
              pend_wr_q           <= 1'b1;
            end
            ST_WSR: begin
              if (!wp_block) begin
                pend_sr_q  <= 1'b1;
                wpen_new_q <= byte_in[7];
                bp_new_q   <= byte_in[3:2];
              end
              st_q <= ST_SKIP;
            end
            ST_RSR:  load_q <= 1'b1;
            default: ;
          endcase
        end
      end else if (fall && out_q && !lock_q) begin
        miso_q <= tx_q[7];
        tx_q   <= {tx_q[6:0], 1'b0};
      end

      // output byte fetched one clock after the address settles
      if (load_q) begin
        load_q <= 1'b0;
        tx_q   <= (st_q == ST_RSR) ? status : mem_rdata;
      end

      if (pend_sr_q && wp_block) pend_sr_q <= 1'b0;

      if (frame_end) begin
        if (sr_go) begin
          wpen_q <= wpen_new_q;
          bp_q   <= bp_new_q;
        end
        pend_sr_q <= 1'b0;
        pend_wr_q <= 1'b0;
      end

      if (tmr_done) wel_q <= 1'b0;

      oe_q <= out_q & sel & ~hold & ~lock_q;
    end
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = oe_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && $past(!sel)) |-> !miso_oe_o);
  a_r4_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && $past(lock_q)) |-> !miso_oe_o);
  a_r10_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && $past(hold)) |-> $stable(bit_q));
  a_r6_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (addr_q[15:PAGE_AW] == $past(addr_q[15:PAGE_AW])));
  a_r8_wel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q);
  a_r12_status_locked_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(wpen_q) && $stable(bp_q)));
endmodule

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int AW    = 6;
  localparam int PW    = 3;
  localparam int WRC   = 400;
  localparam int HALF  = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_oe;

  always #5 clk = ~clk;

  spi_eeprom_slave #(.MEM_AW(AW), .PAGE_AW(PW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_n), .wp_ni(wp_n), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit oe_any, r2_bad, hold_oe;
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] st;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(HALF);
  endtask

  task automatic desel();
    tick(HALF); cs_n = 1'b1; tick(3 * HALF);
  endtask

  task automatic xbyte(input logic [7:0] d, input int hold_at, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        hold_n = 1'b0; tick(HALF);
        for (int k = 0; k < 3; k++) begin
          mosi = ~mosi;
          if (miso_oe) hold_oe = 1'b1;
          sck = 1'b1; tick(HALF);
          if (miso_oe) hold_oe = 1'b1;
          sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1; tick(HALF);
      end
      mosi = d[i]; tick(HALF);
      q[i] = miso;
      if (miso_oe) oe_any = 1'b1;
      sck = 1'b1; tick(HALF - 1);
      if (miso_oe && miso !== q[i]) r2_bad = 1'b1;
      tick(1); sck = 1'b0;
    end
  endtask

  task automatic frame1(input logic [7:0] op);
    logic [7:0] q;
    sel(); xbyte(op, -1, q); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] q;
    sel(); xbyte(8'h05, -1, q); xbyte(8'h00, -1, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v, input bit drop_wp);
    logic [7:0] q;
    sel(); xbyte(8'h01, -1, q); xbyte(v, -1, q);
    if (drop_wp) begin wp_n = 1'b0; tick(HALF); end
    desel();
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed) & 255);
  endfunction

  task automatic write_bytes(input int a, input int n, input int seed, input bit upd);
    logic [7:0] q;
    sel();
    xbyte(8'h02, -1, q); xbyte(8'(a >> 8), -1, q); xbyte(8'(a), -1, q);
    for (int j = 0; j < n; j++) begin
      int wa;
      wa = (a & (DEPTH - 1) & ~(PAGE - 1)) | ((a + j) & (PAGE - 1));
      xbyte(pat(wa, seed), -1, q);
      if (upd) exp_mem[wa] = pat(wa, seed);
    end
    desel();
  endtask

  task automatic read_check(input int a, input int n, input string tag, input bit hold_on);
    logic [7:0] q;
    sel();
    xbyte(8'h03, -1, q); xbyte(8'(a >> 8), -1, q);
    xbyte(8'(a), hold_on ? 4 : -1, q);
    for (int j = 0; j < n; j++) begin
      xbyte(8'h00, (hold_on && j == 0) ? 3 : -1, q);
      chk(tag, q, exp_mem[(a + j) & (DEPTH - 1)]);
    end
    desel();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    // R13 reset state
    chk("R13 oe after reset", miso_oe, 0);
    rdsr(st); chk("R13 status after reset", st, 8'h00);

    // R3 latch opcodes
    frame1(8'h06); rdsr(st); chk("R3 WEL set", st, 8'h02);
    frame1(8'h04); rdsr(st); chk("R3 WEL clear", st, 8'h00);

    // R1 deselected traffic ignored
    oe_any = 0;
    for (int i = 7; i >= 0; i--) begin
      mosi = 1'(8'h06 >> i); tick(HALF);
      if (miso_oe) oe_any = 1; sck = 1'b1; tick(HALF);
      if (miso_oe) oe_any = 1; sck = 1'b0;
    end
    tick(HALF);
    chk("R1 oe while deselected", oe_any, 0);
    rdsr(st); chk("R1 no latch change", st, 8'h00);

    // fill whole array page by page
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      frame1(8'h06);
      write_bytes(p * PAGE, PAGE, 11, 1);
      if (p == 0) begin
        rdsr(st); chk("R8 busy during cycle", st, 8'h03);
      end
      tick(WRC + 100);
      if (p == 0) begin
        rdsr(st); chk("R8 WEL cleared at end", st, 8'h00);
      end
    end

    // R5 sequential read wraps array, high address bits ignored
    r2_bad = 0;
    read_check(16'hFF3C, DEPTH, "R5 read", 0);
    chk("R2 output stable while sck high", r2_bad, 0);

    // R6 page wrap
    frame1(8'h06);
    write_bytes(16'h001E, 4, 99, 1);
    tick(WRC + 100);
    read_check(16'h0018, PAGE, "R6 page wrap", 0);

    // R6 write without latch
    write_bytes(16'h0000, PAGE, 55, 0);
    tick(WRC + 100);
    read_check(16'h0000, PAGE, "R6 no WEL no write", 0);

    // R10 hold in address and data bytes
    hold_oe = 0;
    read_check(16'h0020, 4, "R10 hold resume", 1);
    chk("R10 oe during hold", hold_oe, 0);

    // R4 invalid opcode sweep
    for (int op = 0; op < 256; op++) begin
      logic [7:0] q;
      if (op >= 1 && op <= 6) continue;
      oe_any = 0;
      sel(); xbyte(8'(op), -1, q); xbyte(8'h06, -1, q); xbyte(8'hFF, -1, q); desel();
      chk($sformatf("R4 lockout op %0h", op), oe_any, 0);
    end
    rdsr(st); chk("R4 no latch after lock", st, 8'h00);

    // R9 opcodes ignored while busy
    frame1(8'h06);
    write_bytes(16'h0005, 1, 7, 1);
    rdsr(st); chk("R9 status served while busy", st, 8'h03);
    begin
      logic [7:0] q;
      oe_any = 0;
      sel(); xbyte(8'h03, -1, q); xbyte(8'h00, -1, q); xbyte(8'h05, -1, q);
      xbyte(8'h00, -1, q); desel();
      chk("R9 read ignored while busy", oe_any, 0);
    end
    tick(WRC + 100);
    rdsr(st); chk("R9 idle after cycle", st, 8'h00);
    read_check(16'h0005, 1, "R9 written byte", 0);

    // R7/R11 protect enable
    frame1(8'h06); wrsr(8'h80, 0); tick(WRC + 100);
    rdsr(st); chk("R7 status write", st, 8'h80);
    wp_n = 1'b0;
    frame1(8'h06); wrsr(8'h00, 0); tick(WRC + 100);
    rdsr(st); chk("R11 blocked by wp", st, 8'h82);
    wp_n = 1'b1;

    // R12 abort before frame end, keep after start
    wrsr(8'h00, 1); wp_n = 1'b1; tick(WRC + 100);
    rdsr(st); chk("R12 abort on wp fall", st, 8'h82);
    wrsr(8'h00, 0); wp_n = 1'b0; tick(WRC + 100); wp_n = 1'b1;
    rdsr(st); chk("R12 started cycle completes", st, 8'h00);

    // R11 wp ignored when protect-enable clear
    wp_n = 1'b0;
    frame1(8'h06); wrsr(8'h0C, 0); tick(WRC + 100);
    rdsr(st); chk("R11 wp ignored with enable clear", st, 8'h0C);
    wp_n = 1'b1;

    finished = 1;
    finish_run();
  end
endmodule